// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port. It moves one byte at a time, least significant bit first, over a single data line. It also drives a shift clock on a second line. The data line is split into three signals: an output value, an output enable and an input value. When the port is not transmitting, the output enable is low, so a device at the other end can drive the line.

Software starts a transmission by writing a byte to the buffer. Reception runs whenever receive enable is high, the receive-done flag is clear and the port is idle. Both transfers use the same shift-clock waveform. One speed input picks that waveform from two settings:
- Fast: four input-clock cycles per bit.
- Slow: twelve input-clock cycles per bit.

Each setting has its own fixed data-to-falling-edge setup and its own fixed low-phase length. The speed is captured when a transfer starts. The transmit-done and receive-done flags stay set until software pulses the matching clear input. A completed reception loads the received byte into a read buffer.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, sclk is 1, sdat_oe is 0, tx_done and rx_done are 0, and rd_data is 8'h00.
- R2: A wr_en pulse while the port is idle starts a transmission. sdat_oe is high for the whole transfer. The 8 bits of wr_data appear on sdat_o least significant bit first, one per bit period. Each bit holds steady through the low phase and at the next rising edge of sclk.
- R3: With fast_sel=1 a bit period is 4 cycles. The first falling edge of sclk comes 1 cycle after the transfer starts. sclk stays low for 2 cycles. Between two low phases it stays high for 2 cycles.
- R4: With fast_sel=0 a bit period is 12 cycles. The first falling edge comes 3 cycles after the start. sclk stays low for 6 cycles. Between two low phases it stays high for 6 cycles.
- R5: tx_done rises 8 bit periods after the start edge. At that point sdat_oe is low and sclk is high. tx_done stays 1 until tx_done_clr is pulsed.
- R6: When rx_en=1, rx_done=0 and the port is idle, a reception starts with the same sclk waveform. sdat_oe stays low throughout. sdat_i is sampled at each rising edge of sclk, least significant bit first.
- R7: rx_done rises 8 bit periods after a reception starts, and rd_data then holds the received byte. While rx_done=1, no reception runs and sclk stays 1. After rx_done_clr, with rx_en still 1, a new reception starts.
- R8: wr_en is ignored while a transmission or reception is running. The byte on the line and the transfer length are unaffected.
- R9: fast_sel is sampled only when a transfer starts. Changing it mid-transfer does not alter the running transfer's timing.
- R10: rd_data changes only when a reception completes. Transmissions leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe, starts transmission |
| wr_data | input | 8 | Byte to transmit |
| rx_en | input | 1 | Receive enable |
| fast_sel | input | 1 | 1 = 4-cycle bits, 0 = 12-cycle bits |
| tx_done_clr | input | 1 | Clears tx_done |
| rx_done_clr | input | 1 | Clears rx_done |
| rd_data | output | 8 | Receive buffer |
| tx_done | output | 1 | Transmission complete flag |
| rx_done | output | 1 | Reception complete flag |
| sclk | output | 1 | Shift clock, idles high |
| sdat_o | output | 1 | Data line output value |
| sdat_oe | output | 1 | Data line output enable |
| sdat_i | input | 1 | Data line input value |

## Verification
The assertions assume three things about the inputs:
- Strobes and clear pulses last one cycle.
- The speed input is only meaningful when a transfer starts.
- The far device changes sdat_i only after a falling edge of sclk and holds it through the next rising edge.

The bench drives every input one time unit after a rising clock edge. Its model of the far device reacts only to falling edges of sclk. The mid-transfer writes and speed flips are deliberate. The assertions treat them as legal, ignored events.

// File: rtl/ssp_pkg.sv
// Package: shared types for the synchronous shift-register serial port.
// Assumes: nothing beyond the standard language.
package ssp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TX   = 2'd1,
        ST_RX   = 2'd2
    } ssp_state_e;
endpackage

// File: rtl/ssp_bit_timer.sv
// Module: ssp_bit_timer
// Produces the per-bit phase count and the shift-clock waveform for one
// 8-bit transfer, plus strobes for the sampling edge and the bit end.
// Assumes: start is only raised while the timer is not running; the slow
// period is the longer of the two; setup + low < period for each setting.
module ssp_bit_timer #(
    parameter int BITS       = 8,
    parameter int FAST_DIV   = 4,
    parameter int FAST_SETUP = 1,
    parameter int FAST_LOW   = 2,
    parameter int SLOW_DIV   = 12,
    parameter int SLOW_SETUP = 3,
    parameter int SLOW_LOW   = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic fast_sel,
    output logic sclk,
    output logic sample,
    output logic bit_end,
    output logic xfer_end
);
    localparam int MAX_DIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int PH_W    = $clog2(MAX_DIV);
    localparam int BIT_W   = $clog2(BITS);
    localparam logic [PH_W-1:0]  F_FALL = PH_W'(FAST_SETUP);
    localparam logic [PH_W-1:0]  F_RISE = PH_W'(FAST_SETUP + FAST_LOW);
    localparam logic [PH_W-1:0]  F_LAST = PH_W'(FAST_DIV - 1);
    localparam logic [PH_W-1:0]  S_FALL = PH_W'(SLOW_SETUP);
    localparam logic [PH_W-1:0]  S_RISE = PH_W'(SLOW_SETUP + SLOW_LOW);
    localparam logic [PH_W-1:0]  S_LAST = PH_W'(SLOW_DIV - 1);
    localparam logic [BIT_W-1:0] B_LAST = BIT_W'(BITS - 1);

    logic             run;
    logic             speed_q;
    logic [PH_W-1:0]  phase;
    logic [BIT_W-1:0] bitn;
    logic [PH_W-1:0]  fall_ph, rise_ph, last_ph;

    // Select the phase landmarks of the latched speed setting.
    always_comb begin
        fall_ph = speed_q ? F_FALL : S_FALL;
        rise_ph = speed_q ? F_RISE : S_RISE;
        last_ph = speed_q ? F_LAST : S_LAST;
    end

    // Decode the shift clock and the edge strobes from the phase count.
    always_comb begin
        sclk     = !run || (phase < fall_ph) || (phase >= rise_ph);
        sample   = run && (phase == rise_ph - 1'b1);
        bit_end  = run && (phase == last_ph);
        xfer_end = bit_end && (bitn == B_LAST);
    end

    // Advance the phase and bit counters; latch speed at transfer start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            speed_q <= 1'b0;
            phase   <= '0;
            bitn    <= '0;
        end else if (!run) begin
            if (start) begin
                run     <= 1'b1;
                speed_q <= fast_sel;
                phase   <= '0;
                bitn    <= '0;
            end
        end else if (bit_end) begin
            phase <= '0;
            if (xfer_end) run <= 1'b0;
            else          bitn <= bitn + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Checker state: length of the current low run of the shift clock.
    logic [PH_W:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)     low_run <= '0;
        else if (sclk)  low_run <= '0;
        else            low_run <= low_run + 1'b1;
    end

    assert_low_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && speed_q) |-> (low_run == (PH_W+1)'(FAST_LOW)));
    assert_low_slow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && !speed_q) |-> (low_run == (PH_W+1)'(SLOW_LOW)));
    assert_speed_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(speed_q));
endmodule

// File: rtl/ssp_shift_reg.sv
// Module: ssp_shift_reg
// Shared shift register for both directions: parallel load for transmit,
// right shift with serial fill so the first bit ends in bit 0.
// Assumes: load and shift_en are never high together.
module ssp_shift_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift_en,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    // Load a byte or shift one position toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (load)     q <= load_val;
        else if (shift_en) q <= {shift_in, q[W-1:1]};
    end
endmodule

// File: rtl/ssp_ctrl.sv
// Module: ssp_ctrl
// Transfer sequencer: chooses transmit or receive from idle, holds the done
// flags and the receive buffer.
// Assumes: xfer_end pulses once at the end of each started transfer.
module ssp_ctrl
    import ssp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         rx_en,
    input  logic         tx_done_clr,
    input  logic         rx_done_clr,
    input  logic         xfer_end,
    input  logic [W-1:0] shift_q,
    output logic         start,
    output logic         load_tx,
    output logic         tx_active,
    output logic         rx_active,
    output logic         tx_done,
    output logic         rx_done,
    output logic [W-1:0] rx_buf
);
    ssp_state_e state;
    logic       start_rx;

    // Decide which transfer, if any, begins this cycle.
    always_comb begin
        load_tx   = (state == ST_IDLE) && wr_en;
        start_rx  = (state == ST_IDLE) && !wr_en && rx_en && !rx_done;
        start     = load_tx || start_rx;
        tx_active = (state == ST_TX);
        rx_active = (state == ST_RX);
    end

    // Sequence idle, transmit and receive.
    always_ff @(posedge clk) begin
        if (!rst_n)                        state <= ST_IDLE;
        else if (load_tx)                  state <= ST_TX;
        else if (start_rx)                 state <= ST_RX;
        else if (state != ST_IDLE && xfer_end) state <= ST_IDLE;
    end

    // Done flags: set at transfer end, which wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            if (tx_active && xfer_end) tx_done <= 1'b1;
            else if (tx_done_clr)      tx_done <= 1'b0;
            if (rx_active && xfer_end) rx_done <= 1'b1;
            else if (rx_done_clr)      rx_done <= 1'b0;
        end
    end

    // Capture the received byte when reception completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                     rx_buf <= '0;
        else if (rx_active && xfer_end) rx_buf <= shift_q;
    end

    assert_tx_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> !tx_active);
    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> !rx_active);
    assert_buf_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_buf) |-> $rose(rx_done));
endmodule

// File: rtl/sync_shift_port.sv
// Module: sync_shift_port (top)
// Half-duplex synchronous serial port: byte-wide buffer writes go out LSB
// first on the data line with a generated shift clock; receptions shift the
// line in on rising shift-clock edges.
// Assumes: the far device changes sdat_i after falling sclk edges only.
module sync_shift_port #(
    parameter int W          = 8,
    parameter int FAST_DIV   = 4,
    parameter int FAST_SETUP = 1,
    parameter int FAST_LOW   = 2,
    parameter int SLOW_DIV   = 12,
    parameter int SLOW_SETUP = 3,
    parameter int SLOW_LOW   = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rx_en,
    input  logic         fast_sel,
    input  logic         tx_done_clr,
    input  logic         rx_done_clr,
    output logic [W-1:0] rd_data,
    output logic         tx_done,
    output logic         rx_done,
    output logic         sclk,
    output logic         sdat_o,
    output logic         sdat_oe,
    input  logic         sdat_i
);
    logic         start, load_tx, tx_active, rx_active;
    logic         sample, bit_end, xfer_end, shift_en;
    logic [W-1:0] shift_q;

    ssp_bit_timer #(
        .BITS(W), .FAST_DIV(FAST_DIV), .FAST_SETUP(FAST_SETUP),
        .FAST_LOW(FAST_LOW), .SLOW_DIV(SLOW_DIV),
        .SLOW_SETUP(SLOW_SETUP), .SLOW_LOW(SLOW_LOW)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .fast_sel(fast_sel),
        .sclk(sclk), .sample(sample), .bit_end(bit_end), .xfer_end(xfer_end)
    );

    ssp_shift_reg #(.W(W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load_tx), .load_val(wr_data),
        .shift_en(shift_en), .shift_in(sdat_i), .q(shift_q)
    );

    ssp_ctrl #(.W(W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rx_en(rx_en),
        .tx_done_clr(tx_done_clr), .rx_done_clr(rx_done_clr),
        .xfer_end(xfer_end), .shift_q(shift_q), .start(start),
        .load_tx(load_tx), .tx_active(tx_active), .rx_active(rx_active),
        .tx_done(tx_done), .rx_done(rx_done), .rx_buf(rd_data)
    );

    // Route shift strobes by direction and drive the data line.
    always_comb begin
        shift_en = (tx_active && bit_end) || (rx_active && sample);
        sdat_oe  = tx_active;
        sdat_o   = tx_active && shift_q[0];
    end

    assert_data_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sdat_oe && !sclk) |-> $stable(sdat_o));
endmodule

// File: tb/test_sync_shift_port.sv
module test_sync_shift_port;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 100000;
    // Each entry: {fast_sel, byte}
    localparam logic [8:0] VEC [6] = '{9'h1A5, 9'h03C, 9'h101, 9'h080, 9'h1FF, 9'h05A};

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, rx_en = 0, fast_sel = 0, tx_done_clr = 0, rx_done_clr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic tx_done, rx_done, sclk, sdat_o, sdat_oe;
    logic sdat_i = 0;

    int checks = 0, errors = 0, cyc = 0;
    int hi = 0, lo = 0, bad = 0, rises = 0, oe_bad = 0;
    bit first = 0, mon_on = 0, sclk_prev = 1;
    int exp_setup = 1, exp_low = 2, exp_mid = 2;
    logic [7:0] cap = 0;
    logic [7:0] dev_data = 0;
    int dev_idx = 8;
    logic [7:0] last_rx = 0;

    sync_shift_port i_sync_shift_port (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rx_en(rx_en), .fast_sel(fast_sel), .tx_done_clr(tx_done_clr),
        .rx_done_clr(rx_done_clr), .rd_data(rd_data), .tx_done(tx_done),
        .rx_done(rx_done), .sclk(sclk), .sdat_o(sdat_o), .sdat_oe(sdat_oe),
        .sdat_i(sdat_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            check(0, "R2 watchdog expired", cyc, WDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Waveform monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (mon_on) begin
            if (sclk && !sclk_prev) begin
                if (lo != exp_low) bad++;
                cap = {sdat_o, cap[7:1]};
                rises++;
                hi = 1;
            end else if (sclk) begin
                hi++;
            end else if (sclk_prev) begin
                if (hi != (first ? exp_setup : exp_mid)) bad++;
                first = 0;
                lo = 1;
            end else begin
                lo++;
            end
            if (sdat_oe) oe_bad++;
        end
        sclk_prev = sclk;
    end

    // Far device: presents the next bit after each falling edge.
    always @(negedge sclk) begin
        if (dev_idx < 8) begin
            sdat_i = dev_data[dev_idx];
            dev_idx++;
        end
    end

    function automatic int period(input bit f);
        return f ? 4 : 12;
    endfunction

    task automatic arm(input bit f);
        exp_setup = f ? 1 : 3;
        exp_low   = f ? 2 : 6;
        exp_mid   = f ? 2 : 6;
        hi = 0; lo = 0; bad = 0; rises = 0; cap = 0; first = 1; oe_bad = 0;
        mon_on = 1;
    endtask

    task automatic run_tx(input bit f, input logic [7:0] d, input bit poke);
        int n;
        fast_sel = f;
        @(posedge clk); #1 wr_en = 1; wr_data = d;
        @(posedge clk); #1 wr_en = 0;
        arm(f);
        check(sdat_oe == 1, "R2 oe during transmit", sdat_oe, 1);
        n = 0;
        while (!tx_done && n < 400) begin
            @(posedge clk); #1 n++;
            if (n == 5 && poke) begin
                wr_en = 1; wr_data = ~d; fast_sel = !f;   // R8 / R9 stimulus
            end
            if (n == 6) wr_en = 0;
            if (sdat_oe == 0 && !tx_done) oe_bad += 1000;
        end
        mon_on = 0;
        check(n == 8*period(f), f ? "R3 fast tx length" : "R4 slow tx length", n, 8*period(f));
        check(cap == d, poke ? "R8 tx byte after ignored write" : "R2 tx byte LSB first", cap, d);
        check(bad == 0 && rises == 8, poke ? "R9 waveform after speed flip" :
              (f ? "R3 fast waveform" : "R4 slow waveform"), bad, 0);
        check(!sdat_oe && sclk, "R5 line released at done", sdat_oe, 0);
        check(rd_data == last_rx, "R10 rd_data unchanged by transmit", rd_data, last_rx);
        repeat (3) @(posedge clk);
        #1 check(tx_done == 1, "R5 tx_done held", tx_done, 1);
        tx_done_clr = 1;
        @(posedge clk); #1 tx_done_clr = 0;
        check(tx_done == 0, "R5 tx_done cleared", tx_done, 0);
        fast_sel = f;
    endtask

    task automatic run_rx(input bit f, input logic [7:0] d, input bit poke);
        int n;
        fast_sel = f;
        dev_data = d; dev_idx = 0;
        @(posedge clk); #1 rx_en = 1;
        @(posedge clk); #1 arm(f);
        n = 0;
        while (!rx_done && n < 400) begin
            @(posedge clk); #1 n++;
            if (n == 5 && poke) begin wr_en = 1; wr_data = ~d; end   // R8 stimulus
            if (n == 6) wr_en = 0;
        end
        rx_en = 0;
        mon_on = 0;
        check(n == 8*period(f), f ? "R3 fast rx length" : "R4 slow rx length", n, 8*period(f));
        check(rd_data == d, "R6 received byte", rd_data, d);
        check(oe_bad == 0, poke ? "R8 write ignored during receive" : "R6 line not driven", oe_bad, 0);
        check(bad == 0, "R6 rx waveform", bad, 0);
        last_rx = d;
        rx_done_clr = 1;
        @(posedge clk); #1 rx_done_clr = 0;
        check(rx_done == 0, "R7 rx_done cleared", rx_done, 0);
        dev_idx = 8;
    endtask

    initial begin
        int lows;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(sclk == 1, "R1 sclk idle high", sclk, 1);
        check(sdat_oe == 0, "R1 oe low", sdat_oe, 0);
        check(tx_done == 0 && rx_done == 0, "R1 flags clear", {tx_done, rx_done}, 0);
        check(rd_data == 0, "R1 rd_data zero", rd_data, 0);

        foreach (VEC[i]) begin
            run_tx(VEC[i][8], VEC[i][7:0], 0);
            run_rx(VEC[i][8], ~VEC[i][7:0], 0);
        end

        // R8 and R9: write and speed flip during transmit
        run_tx(1, 8'hC3, 1);
        run_tx(0, 8'h96, 1);
        // R8: write during receive
        run_rx(1, 8'h6E, 1);

        // R7: no reception while rx_done is set, restart after clear
        fast_sel = 1; dev_data = 8'h2D; dev_idx = 0;
        @(posedge clk); #1 rx_en = 1;
        while (!rx_done) begin @(posedge clk); #1; end
        check(rd_data == 8'h2D, "R7 byte before hold", rd_data, 8'h2D);
        lows = 0;
        repeat (40) begin @(negedge clk); if (!sclk) lows++; end
        check(lows == 0, "R7 sclk idle while rx_done set", lows, 0);
        check(rd_data == 8'h2D, "R7 buffer held", rd_data, 8'h2D);
        @(posedge clk); #1 rx_done_clr = 1;
        @(posedge clk); #1 rx_done_clr = 0;
        lows = 0;
        repeat (6) begin @(negedge clk); if (!sclk) lows++; end
        check(lows > 0, "R7 reception restarts after clear", lows, 1);
        @(posedge clk); #1 rx_en = 0;
        while (!rx_done) begin @(posedge clk); #1; end
        rx_done_clr = 1;
        @(posedge clk); #1 rx_done_clr = 0;
        check(rx_done == 0 && sclk == 1, "R7 idle after final clear", rx_done, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule